// File: doc/BRIEF.md
# Dual-mode serial binary-field multiplier

This block multiplies binary polynomials one stage per clock. It runs in one of two modes, and the mode is chosen for each operation.

**Field mode.** The block computes the product of two W-bit field elements, reduced by a programmable W-degree modulus. The leading term of the modulus is implied; its lower W coefficients are supplied on the shared operand port. At every stage the multiplicand is shifted left. If a bit leaves the top, the modulus coefficients are folded back in, so the running result is already reduced.

**Window mode.** The same datapath acts as a carry-less multiplier with a 2W-bit multiplicand made of an upper word and a lower word. Folding is masked off. At each stage the next bit of the lower word, starting from its most significant bit, enters the freed least significant position. The W-bit output is one word of the product of a long polynomial and one multiplier word, with the word alignment already applied. A caller that steps along a long polynomial word by word therefore needs no extra XOR to stitch together neighbouring partial products.

An operation starts with a one-cycle start pulse. The operands and the mode are captured at that edge. A one-cycle done flag marks the completion, and the result stays on its port until the next completion.

Top module: `gf2_window_mul`

## Requirements
- R1: With reduce_i = 1, result_o equals (mcand_hi_i · mplier_i) mod (x^W + mcand_lo_i). Bit i of each port is the coefficient of x^i.
- R2: With reduce_i = 0, result_o equals the XOR, over every i where mplier_i[i] = 1, of bits [2W-1:W] of the 2W-bit value {mcand_hi_i, mcand_lo_i} shifted left by i. Bits pushed above position 2W-1 are discarded and no modulus is applied.
- R3: done_o goes high exactly W clock edges after the edge that accepted start_i, and stays high for a single cycle.
- R4: result_o changes only in the cycle where done_o is high. It keeps its value through idle cycles, and changes on the other inputs while idle do not affect it.
- R5: A start_i pulse while an operation is in progress is ignored. The running operation finishes with its own operands and timing, and the ignored pulse produces no later completion.
- R6: After reset, done_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| reduce_i | input | 1 | 1 = field mode, 0 = window mode |
| mcand_hi_i | input | W | Field mode: multiplicand. Window mode: upper multiplicand word |
| mcand_lo_i | input | W | Field mode: modulus coefficients x^0..x^(W-1). Window mode: lower multiplicand word |
| mplier_i | input | W | Multiplier word |
| result_o | output | W | Result of the last completed operation |
| done_o | output | 1 | One-cycle completion flag |

## Verification
An error in the stage counter shows at the ports as a done pulse arriving early or late, or a second done pulse appearing. This is visible within one operation, about W cycles after start.

Errors inside the datapath are harder to miss once several operands are tried:
- Feedback leaking into window mode, or the lower-word tap entering field mode, corrupts the low bits of result_o.
- A wrong tap position misaligns the window bits.

Such errors appear in the first result that exercises them. Operands are chosen so that single high bits, all-ones words and pseudo-random words each reveal a different slip.

// File: rtl/gf2wm_pkg.sv
package gf2wm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gf2wm_state_e;

endpackage

// File: rtl/gf2wm_stage.sv
module gf2wm_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] poly_i,
  input  logic         mul_bit_i,
  input  logic         lo_bit_i,
  input  logic         reduce_i,
  output logic [W-1:0] mcand_o,
  output logic [W-1:0] acc_o,
  output logic         fb_o,
  output logic         ins_o
);

  logic [W-1:0] poly_gate;
  logic [W-1:0] shifted;

  // Fold request: top bit leaving the word, honoured only in field mode.
  assign fb_o  = mcand_i[W-1] & reduce_i;
  // Lower-word tap enters the vacated bit only in window mode.
  assign ins_o = lo_bit_i & ~reduce_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign poly_gate[i] = poly_i[i] & fb_o;
    if (i == 0) begin : g_lsb
      assign shifted[i] = ins_o;
    end else begin : g_mid
      assign shifted[i] = mcand_i[i-1];
    end
    assign mcand_o[i] = shifted[i] ^ poly_gate[i];
    assign acc_o[i]   = acc_i[i] ^ (mcand_i[i] & mul_bit_i);
  end

endmodule

// File: rtl/gf2wm_ctrl.sv
module gf2wm_ctrl
  import gf2wm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic last_o
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  gf2wm_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign busy_o   = (state_q == ST_RUN);
  assign accept_o = start_i & ~busy_o;
  assign last_o   = busy_o & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  // R5: a run is not disturbed by start; the stage count keeps advancing
  a_r5_count_advances : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + CW'(1)));

  // R3: the run ends right after the last stage
  a_r3_run_ends : assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_o);

endmodule

// File: rtl/gf2_window_mul.sv
module gf2_window_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         reduce_i,
  input  logic [W-1:0] mcand_hi_i,
  input  logic [W-1:0] mcand_lo_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);

  logic         accept;
  logic         busy;
  logic         last_stage;
  logic [W-1:0] mcand_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] mul_q;
  logic         mode_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] mcand_nxt;
  logic [W-1:0] acc_nxt;
  logic         fb_active;
  logic         ins_bit;
  logic [W-1:0] result_q;
  logic         done_q;

  gf2wm_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last_stage)
  );

  gf2wm_stage #(.W(W)) u_stage (
    .mcand_i   (mcand_q),
    .acc_i     (acc_q),
    .poly_i    (lo_q),
    .mul_bit_i (mul_q[0]),
    .lo_bit_i  (lo_q[W-1]),
    .reduce_i  (mode_q),
    .mcand_o   (mcand_nxt),
    .acc_o     (acc_nxt),
    .fb_o      (fb_active),
    .ins_o     (ins_bit)
  );

  // Operand and stage registers. In window mode lo_q is a tap shifter;
  // in field mode it holds the modulus steady.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      lo_q    <= '0;
      mul_q   <= '0;
      mode_q  <= 1'b0;
      acc_q   <= '0;
    end else if (accept) begin
      mcand_q <= mcand_hi_i;
      lo_q    <= mcand_lo_i;
      mul_q   <= mplier_i;
      mode_q  <= reduce_i;
      acc_q   <= '0;
    end else if (busy) begin
      mcand_q <= mcand_nxt;
      acc_q   <= acc_nxt;
      mul_q   <= mul_q >> 1;
      if (!mode_q) begin
        lo_q <= lo_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_stage;
      if (last_stage) begin
        result_q <= acc_nxt;
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R3: completion flag follows the last stage and lasts one cycle
  a_r3_done_after_last : assert property (@(posedge clk) disable iff (!rst_n)
    last_stage |=> done_o);
  a_r3_done_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: result only moves together with a completion
  a_r4_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R2: window mode never folds the modulus back in
  a_r2_no_feedback : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !fb_active);

  // R1: field mode never feeds the lower-word tap into the shifted LSB
  a_r1_no_insert : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> !ins_bit);

endmodule

// File: tb/test_gf2_window_mul.sv
module test_gf2_window_mul;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         reduce_i = 1'b0;
  logic [W-1:0] mcand_hi_i = '0;
  logic [W-1:0] mcand_lo_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int checks = 0;
  int fails = 0;
  int cycle_no = 0;
  logic [31:0] seed = 32'h1234_5678;

  gf2_window_mul #(.W(W)) i_gf2_window_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .reduce_i   (reduce_i),
    .mcand_hi_i (mcand_hi_i),
    .mcand_lo_i (mcand_lo_i),
    .mplier_i   (mplier_i),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycle_no <= cycle_no + 1;
    if (cycle_no > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cycle_no);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Full product, then long division by x^W + p: independent of the stage loop.
  function automatic logic [W-1:0] ref_field(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] p);
    logic [2*W-1:0] prod = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) prod = prod ^ ({{W{1'b0}}, a} << i);
    for (int i = 2*W-2; i >= W; i--)
      if (prod[i]) prod = prod ^ ((2*W)'({1'b1, p}) << (i - W));
    return prod[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_window(logic [W-1:0] hi, logic [W-1:0] lo,
                                              logic [W-1:0] b);
    logic [2*W-1:0] cat = {hi, lo};
    logic [2*W-1:0] tmp;
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      tmp = cat << i;
      if (b[i]) r = r ^ tmp[2*W-1:W];
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Wait for done; returns negedges counted since the accepting edge.
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (done_o !== 1'b1 && cyc <= 4*W) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
  endtask

  task automatic run_op(string req, logic mode, logic [W-1:0] hi, logic [W-1:0] lo,
                        logic [W-1:0] b, logic [W-1:0] exp);
    int cyc;
    @(negedge clk);
    reduce_i = mode; mcand_hi_i = hi; mcand_lo_i = lo; mplier_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check("R3 latency", W'(cyc), W'(W));
    check(req, result_o, exp);
    @(negedge clk);
    check("R3 done one cycle", W'(done_o), W'(0));
  endtask

  task automatic t_reset();
    check("R6 done at reset", W'(done_o), W'(0));
    check("R6 result at reset", result_o, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R6 done after reset", W'(done_o), W'(0));
    check("R6 result after reset", result_o, '0);
  endtask

  task automatic t_field();
    logic [W-1:0] a, b, p;
    run_op("R1 wraps x^32", 1'b1, 32'h8000_0000, 32'h0000_008D, 32'h2, 32'h0000_008D);
    run_op("R1 identity", 1'b1, 32'hDEAD_BEEF, 32'h0000_008D, 32'h1, 32'hDEAD_BEEF);
    run_op("R1 zero", 1'b1, 32'hDEAD_BEEF, 32'h0000_008D, 32'h0, 32'h0);
    run_op("R1 all ones", 1'b1, 32'hFFFF_FFFF, 32'h0000_008D, 32'hFFFF_FFFF,
           ref_field(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_008D));
    for (int k = 0; k < 5; k++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      seed = next_rand(seed); p = seed | 32'h1;
      run_op("R1 random", 1'b1, a, p, b, ref_field(a, b, p));
    end
  endtask

  task automatic t_window();
    logic [W-1:0] a, b, c;
    run_op("R2 lower msb tap", 1'b0, 32'h0, 32'h8000_0000, 32'h2, 32'h1);
    run_op("R2 no fold", 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h3, 32'h1);
    run_op("R2 upper only", 1'b0, 32'h8000_0001, 32'h0, 32'h1, 32'h8000_0001);
    run_op("R2 lower only", 1'b0, 32'h0, 32'hF000_0000, 32'h8000_0000, 32'h7800_0000);
    for (int k = 0; k < 5; k++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); c = seed;
      seed = next_rand(seed); b = seed;
      run_op("R2 random", 1'b0, a, c, b, ref_window(a, c, b));
    end
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic [W-1:0] exp;
    exp = ref_field(32'h1357_9BDF, 32'h0F0F_0F0F, 32'h0000_008D);
    @(negedge clk);
    reduce_i = 1'b1; mcand_hi_i = 32'h1357_9BDF; mcand_lo_i = 32'h0000_008D;
    mplier_i = 32'h0F0F_0F0F; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    reduce_i = 1'b0; mcand_hi_i = 32'hAAAA_5555; mcand_lo_i = 32'h1234_4321;
    mplier_i = 32'hFFFF_0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check("R5 latency unchanged", W'(cyc + 6), W'(W));
    check("R5 first operands kept", result_o, exp);
    cyc = 0;
    repeat (W + 4) begin
      @(negedge clk);
      if (done_o) cyc = cyc + 1;
    end
    check("R5 no extra completion", W'(cyc), W'(0));
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    int seen;
    run_op("R1 before hold", 1'b1, 32'h0000_0003, 32'h0000_008D, 32'h0000_0003, 32'h5);
    held = result_o;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mcand_hi_i = W'(k * 77); mplier_i = ~W'(k); reduce_i = k[0];
      if (done_o) seen = seen + 1;
    end
    check("R4 result held", result_o, held);
    check("R4 no done while idle", W'(seen), W'(0));
  endtask

  task automatic t_mode_contrast();
    run_op("R1 same operands field", 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h3,
           ref_field(32'hFFFF_FFFF, 32'h3, 32'h0));
    run_op("R2 same operands window", 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h3, 32'h1);
  endtask

  initial begin
    t_reset();
    t_field();
    t_window();
    t_busy_ignore();
    t_hold();
    t_mode_contrast();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule